// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block sits between a processor-side request port and an asynchronous parallel NOR flash bus. A request names one of three jobs: write one byte at an address, clear one sector, or clear the entire device. The engine turns that request into the fixed series of unlock and command writes the flash expects. It then reads the flash repeatedly until the job reports completion or a read budget runs out.

Each bus access is stretched over a parameterised number of clocks. Address and data are set up one clock before the strobes fall and held one clock after they rise. Completion is judged differently per job. A byte write is finished once the polled byte at the target address reads back as the byte written. An erase is finished once the polled location reads all ones. A one-clock `done` pulse ends every accepted request, with `err` telling success from failure. An abort input stops the series between accesses. Because the flash will only honour a complete series, any later request starts again from the first unlock write.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is asserted and just after it, `req_ready` is 1, `done` is 0, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1 and `fl_dq_oe` is 0.
- R2: A request with `req_op` = 2'b00 (byte program) produces exactly four bus writes, in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then `req_addr`/`req_data`.
- R3: A request with `req_op` = 2'b01 (sector erase) produces exactly six bus writes: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then `req_addr`/0x30.
- R4: A request with `req_op[1]` = 1 (chip erase) produces the same first five writes as R3 and ends with 0x555/0x10.
- R5: After a program sequence, the engine reads `req_addr` and stops once the read value equals `req_data`. A value of 0xFF that differs from `req_data` does not end the polling.
- R6: After an erase sequence, the engine reads `req_addr` and stops at the first read that returns 0xFF.
- R7: If POLL_MAX consecutive polls fail, the engine ends the request with `err` = 1 and makes no further reads.
- R8: `req_ready` is 1 only while idle. A request is taken on a clock where `req_valid` and `req_ready` are both 1. `req_valid` while busy has no effect. Taking a request clears `err`.
- R9: `done` is high for exactly one clock per accepted request. `err` is valid in that clock and holds until the next request is taken.
- R10: In every bus write, `fl_ce_n` and `fl_we_n` are low together for exactly STRB_CLKS clocks, with `fl_oe_n` high and `fl_dq_oe` high. `fl_addr` and `fl_dout` are stable from one clock before the strobes fall until one clock after they rise.
- R11: In every bus read, `fl_ce_n` and `fl_oe_n` are low together for exactly STRB_CLKS clocks, with `fl_we_n` high, `fl_dq_oe` low, and the address stable as in R10.
- R12: A clock with `req_abort` = 1 while busy prevents any further bus access from starting. An access already in progress completes. The request then ends with `done` and `err` = 1, and the next request begins again at 0x555/0xAA. `req_abort` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_op | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| req_addr | input | ADDR_W | Byte address (program) or sector address (erase) |
| req_data | input | 8 | Byte to program |
| req_abort | input | 1 | Stop the running request between accesses |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Request failed by timeout or abort |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dout | output | 8 | Data driven toward the flash |
| fl_din | input | 8 | Data read from the flash |
| fl_dq_oe | output | 1 | Enable for the data bus driver |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash read strobe, active low |

## Verification
The bound checker watches bus shape on every clock: strobe widths, mutual exclusion of write and read strobes, the data driver direction, and address and data stability around each strobe. It also watches the handshake: the done pulse is single, `req_ready` falls after acceptance and is low during `done`. Only the bench scenarios can show the content of each command series, the poll address, and the per-operation success test, including a program whose busy status reads 0xFF. They also cover the exact read count at timeout and the restart after an abort, because these need a flash model that logs writes and answers reads.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

    localparam int unsigned DQ_W = 8;

    localparam logic [DQ_W-1:0] CMD_KEY1   = 8'hAA;
    localparam logic [DQ_W-1:0] CMD_KEY2   = 8'h55;
    localparam logic [DQ_W-1:0] CMD_ERASE  = 8'h80;
    localparam logic [DQ_W-1:0] CMD_WRBYTE = 8'hA0;
    localparam logic [DQ_W-1:0] CMD_CHIP   = 8'h10;
    localparam logic [DQ_W-1:0] CMD_SECTOR = 8'h30;
    localparam logic [DQ_W-1:0] BLANK_VAL  = 8'hFF;

    localparam logic [11:0] KEY_ADDR_HI = 12'h555;
    localparam logic [11:0] KEY_ADDR_LO = 12'h2AA;

    typedef enum logic [1:0] {
        JOB_PROG,
        JOB_SECT,
        JOB_CHIP
    } job_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_POLL,
        SQ_PWAIT,
        SQ_FIN
    } seq_st_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STRB,
        PH_HOLD
    } bus_ph_e;

endpackage

// File: rtl/flash_step_rom.sv
`timescale 1ns/1ps
module flash_step_rom
    import flash_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  job_e              job,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DQ_W-1:0]   tgt_data,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DQ_W-1:0]   cyc_data,
    output logic              cyc_last
);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(KEY_ADDR_HI);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(KEY_ADDR_LO);

    always_comb begin
        cyc_addr = A_HI;
        cyc_data = CMD_KEY1;
        cyc_last = 1'b0;
        if (job == JOB_PROG) begin
            case (step)
                3'd0: begin cyc_addr = A_HI; cyc_data = CMD_KEY1; end
                3'd1: begin cyc_addr = A_LO; cyc_data = CMD_KEY2; end
                3'd2: begin cyc_addr = A_HI; cyc_data = CMD_WRBYTE; end
                default: begin
                    cyc_addr = tgt_addr;
                    cyc_data = tgt_data;
                    cyc_last = 1'b1;
                end
            endcase
        end else begin
            case (step)
                3'd0: begin cyc_addr = A_HI; cyc_data = CMD_KEY1; end
                3'd1: begin cyc_addr = A_LO; cyc_data = CMD_KEY2; end
                3'd2: begin cyc_addr = A_HI; cyc_data = CMD_ERASE; end
                3'd3: begin cyc_addr = A_HI; cyc_data = CMD_KEY1; end
                3'd4: begin cyc_addr = A_LO; cyc_data = CMD_KEY2; end
                default: begin
                    cyc_last = 1'b1;
                    if (job == JOB_CHIP) begin
                        cyc_addr = A_HI;
                        cyc_data = CMD_CHIP;
                    end else begin
                        cyc_addr = tgt_addr;
                        cyc_data = CMD_SECTOR;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/flash_bus_cyc.sv
`timescale 1ns/1ps
module flash_bus_cyc
    import flash_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned STRB_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   wdata,
    input  logic [DQ_W-1:0]   din,
    output logic              cyc_done,
    output logic [DQ_W-1:0]   rdata,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DQ_W-1:0]   fl_dout,
    output logic              fl_dq_oe,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    localparam int unsigned CW = (STRB_CLKS < 2) ? 1 : $clog2(STRB_CLKS);
    localparam logic [CW-1:0] CNT_LAST = CW'(STRB_CLKS - 1);

    typedef struct packed {
        bus_ph_e           ph;
        logic [CW-1:0]     cnt;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   data;
        logic [DQ_W-1:0]   rdat;
    } bus_r_t;

    bus_r_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.ph)
            PH_IDLE: begin
                if (start) begin
                    r_d.ph   = PH_SETUP;
                    r_d.rd   = rd;
                    r_d.addr = addr;
                    r_d.data = wdata;
                end
            end
            PH_SETUP: begin
                r_d.ph  = PH_STRB;
                r_d.cnt = '0;
            end
            PH_STRB: begin
                if (r_q.cnt == CNT_LAST) begin
                    r_d.ph = PH_HOLD;
                    if (r_q.rd) r_d.rdat = din;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cyc_done = (r_q.ph == PH_HOLD);
    assign rdata    = r_q.rdat;
    assign fl_addr  = r_q.addr;
    assign fl_dout  = r_q.data;
    assign fl_dq_oe = (r_q.ph != PH_IDLE) && !r_q.rd;
    assign fl_ce_n  = !(r_q.ph == PH_STRB);
    assign fl_we_n  = !((r_q.ph == PH_STRB) && !r_q.rd);
    assign fl_oe_n  = !((r_q.ph == PH_STRB) && r_q.rd);
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned STRB_CLKS = 2,
    parameter int unsigned POLL_MAX  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              req_abort,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_dout,
    input  logic [7:0]        fl_din,
    output logic              fl_dq_oe,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    localparam int unsigned PW = $clog2(POLL_MAX + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);

    typedef struct packed {
        seq_st_e           st;
        job_e              job;
        logic [2:0]        step;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   data;
        logic [PW-1:0]     polls;
        logic              abort;
        logic              err;
    } seq_r_t;

    seq_r_t r_q, r_d;

    logic              cyc_start, cyc_rd, cyc_done;
    logic [ADDR_W-1:0] cyc_addr, rom_addr;
    logic [DQ_W-1:0]   cyc_wdata, rom_data, cyc_rdata, poll_want;
    logic              rom_last;

    flash_step_rom #(.ADDR_W(ADDR_W)) u_rom (
        .job      (r_q.job),
        .step     (r_q.step),
        .tgt_addr (r_q.addr),
        .tgt_data (r_q.data),
        .cyc_addr (rom_addr),
        .cyc_data (rom_data),
        .cyc_last (rom_last)
    );

    flash_bus_cyc #(.ADDR_W(ADDR_W), .STRB_CLKS(STRB_CLKS)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .rd       (cyc_rd),
        .addr     (cyc_addr),
        .wdata    (cyc_wdata),
        .din      (fl_din),
        .cyc_done (cyc_done),
        .rdata    (cyc_rdata),
        .fl_addr  (fl_addr),
        .fl_dout  (fl_dout),
        .fl_dq_oe (fl_dq_oe),
        .fl_ce_n  (fl_ce_n),
        .fl_we_n  (fl_we_n),
        .fl_oe_n  (fl_oe_n)
    );

    assign poll_want = (r_q.job == JOB_PROG) ? r_q.data : BLANK_VAL;

    always_comb begin
        r_d       = r_q;
        cyc_start = 1'b0;
        cyc_rd    = 1'b0;
        cyc_addr  = rom_addr;
        cyc_wdata = rom_data;

        if (req_abort && (r_q.st != SQ_IDLE) && (r_q.st != SQ_FIN)) begin
            r_d.abort = 1'b1;
        end

        case (r_q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    r_d.st    = SQ_ISSUE;
                    r_d.job   = (req_op == 2'b00) ? JOB_PROG :
                                (req_op == 2'b01) ? JOB_SECT : JOB_CHIP;
                    r_d.addr  = req_addr;
                    r_d.data  = req_data;
                    r_d.step  = '0;
                    r_d.polls = '0;
                    r_d.abort = 1'b0;
                    r_d.err   = 1'b0;
                end
            end
            SQ_ISSUE: begin
                if (r_q.abort || req_abort) begin
                    r_d.st  = SQ_FIN;
                    r_d.err = 1'b1;
                end else begin
                    cyc_start = 1'b1;
                    r_d.st    = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (cyc_done) begin
                    if (rom_last) begin
                        r_d.st = SQ_POLL;
                    end else begin
                        r_d.step = r_q.step + 3'd1;
                        r_d.st   = SQ_ISSUE;
                    end
                end
            end
            SQ_POLL: begin
                if (r_q.abort || req_abort) begin
                    r_d.st  = SQ_FIN;
                    r_d.err = 1'b1;
                end else begin
                    cyc_start = 1'b1;
                    cyc_rd    = 1'b1;
                    cyc_addr  = r_q.addr;
                    r_d.st    = SQ_PWAIT;
                end
            end
            SQ_PWAIT: begin
                if (cyc_done) begin
                    if (cyc_rdata == poll_want) begin
                        r_d.st = SQ_FIN;
                    end else if (r_q.polls == POLL_LAST) begin
                        r_d.st  = SQ_FIN;
                        r_d.err = 1'b1;
                    end else begin
                        r_d.polls = r_q.polls + 1'b1;
                        r_d.st    = SQ_POLL;
                    end
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SQ_IDLE, job: JOB_PROG, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == SQ_IDLE);
    assign done      = (r_q.st == SQ_FIN);
    assign err       = r_q.err;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
`timescale 1ns/1ps
module flash_cmd_seq_chk #(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned STRB_CLKS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_dout,
    input logic              fl_dq_oe,
    input logic              fl_ce_n,
    input logic              fl_we_n,
    input logic              fl_oe_n
);
    logic [15:0] we_low_q, oe_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_q <= '0;
            oe_low_q <= '0;
        end else begin
            we_low_q <= fl_we_n ? 16'd0 : we_low_q + 16'd1;
            oe_low_q <= fl_oe_n ? 16'd0 : oe_low_q + 16'd1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (req_ready && !done && fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe));

    assert_we_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (we_low_q == 16'(STRB_CLKS)));

    assert_we_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

    assert_bus_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_ce_n || $rose(fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

    assert_oe_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_oe_n) |-> (oe_low_q == 16'(STRB_CLKS)));

    assert_oe_nodrive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_ce_n && fl_we_n && !fl_dq_oe));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_on_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_not_ready_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
    .ADDR_W    (ADDR_W),
    .STRB_CLKS (STRB_CLKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .fl_addr   (fl_addr),
    .fl_dout   (fl_dout),
    .fl_dq_oe  (fl_dq_oe),
    .fl_ce_n   (fl_ce_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n)
);

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
    localparam int AW   = 17;
    localparam int STRB = 2;
    localparam int PMAX = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_abort = 1'b0;
    logic          done, err;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dout, fl_din;
    logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

    always #2 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .STRB_CLKS(STRB), .POLL_MAX(PMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_abort(req_abort), .done(done), .err(err), .fl_addr(fl_addr),
        .fl_dout(fl_dout), .fl_din(fl_din), .fl_dq_oe(fl_dq_oe),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    // flash model: logs writes, answers polls
    int            nw = 0, nr = 0, rbad = 0, wbad = 0, obad = 0;
    int            wlo = 0, olo = 0, busy_left = 0;
    logic [AW-1:0] wa [16];
    logic [7:0]    wd [16];
    logic [AW-1:0] exp_raddr = '0;
    logic [7:0]    busy_val = 8'h00, good_val = 8'hFF;
    logic          we_prev = 1'b1, oe_prev = 1'b1;

    assign fl_din = (busy_left > 0) ? busy_val : good_val;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!fl_we_n) wlo++;
            if (!fl_oe_n) olo++;
            if (fl_we_n && !we_prev) begin
                if (nw < 16) begin
                    wa[nw] = fl_addr;
                    wd[nw] = fl_dout;
                end
                nw++;
                if (wlo != STRB || !fl_dq_oe) wbad++;
                wlo = 0;
            end
            if (fl_oe_n && !oe_prev) begin
                nr++;
                if (fl_addr != exp_raddr) rbad++;
                if (olo != STRB || fl_dq_oe) obad++;
                olo = 0;
                if (busy_left > 0) busy_left--;
            end
        end
        we_prev = fl_we_n;
        oe_prev = fl_oe_n;
    end

    int nchk = 0, nbad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic model_setup(input logic [AW-1:0] raddr, input int busy,
                               input logic [7:0] bval, input logic [7:0] gval);
        nw = 0; nr = 0; rbad = 0; wbad = 0; obad = 0;
        exp_raddr = raddr; busy_left = busy; busy_val = bval; good_val = gval;
    endtask

    task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d);
        while (!req_ready) tick();
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic e);
        while (!done) tick();
        e = err;
        tick();
        check(done == 1'b0, "R9", "done longer than one clock", done, 0);
        check(err == e, "R9", "err not held after done", err, e);
        check(req_ready == 1'b1, "R8", "ready after done", req_ready, 1);
    endtask

    task automatic check_write(input int i, input logic [AW-1:0] a, input logic [7:0] d,
                               input string req);
        check(wa[i] == a, req, $sformatf("write %0d address", i), int'(wa[i]), int'(a));
        check(wd[i] == d, req, $sformatf("write %0d data", i), int'(wd[i]), int'(d));
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R1", "strobes in reset",
              {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
        check(fl_dq_oe == 1'b0, "R1", "driver in reset", fl_dq_oe, 0);
    endtask

    task automatic t_program();
        logic e;
        // busy reads return 0xFF, which must not end a program poll (R5)
        model_setup(17'h01234, 3, 8'hFF, 8'h5A);
        send(2'b00, 17'h01234, 8'h5A);
        wait_done(e);
        check(nw == 4, "R2", "program write count", nw, 4);
        check_write(0, 17'h555, 8'hAA, "R2");
        check_write(1, 17'h2AA, 8'h55, "R2");
        check_write(2, 17'h555, 8'hA0, "R2");
        check_write(3, 17'h01234, 8'h5A, "R2");
        check(nr == 4, "R5", "program poll count", nr, 4);
        check(rbad == 0, "R5", "program poll address", rbad, 0);
        check(e == 1'b0, "R9", "program err", e, 0);
        check(wbad == 0, "R10", "write strobe shape", wbad, 0);
        check(obad == 0, "R11", "read strobe shape", obad, 0);
    endtask

    task automatic t_sector_busy_req();
        logic e;
        model_setup(17'h0C000, 2, 8'h00, 8'hFF);
        send(2'b01, 17'h0C000, 8'h00);
        // request held while busy must be ignored (R8)
        req_op = 2'b00; req_addr = 17'h00077; req_data = 8'h11; req_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            check(req_ready == 1'b0, "R8", "ready while busy", req_ready, 0);
            tick();
        end
        req_valid = 1'b0;
        wait_done(e);
        check(nw == 6, "R3", "sector erase write count", nw, 6);
        check_write(0, 17'h555, 8'hAA, "R3");
        check_write(1, 17'h2AA, 8'h55, "R3");
        check_write(2, 17'h555, 8'h80, "R3");
        check_write(3, 17'h555, 8'hAA, "R3");
        check_write(4, 17'h2AA, 8'h55, "R3");
        check_write(5, 17'h0C000, 8'h30, "R3");
        check(nr == 3, "R6", "erase poll count", nr, 3);
        check(rbad == 0, "R6", "erase poll address", rbad, 0);
        check(e == 1'b0, "R6", "erase err", e, 0);
        repeat (20) tick();
        check(nw == 6, "R8", "writes after ignored request", nw, 6);
    endtask

    task automatic t_chip();
        logic e;
        model_setup(17'h00000, 0, 8'h00, 8'hFF);
        send(2'b10, 17'h00000, 8'h00);
        wait_done(e);
        check(nw == 6, "R4", "chip erase write count", nw, 6);
        check_write(2, 17'h555, 8'h80, "R4");
        check_write(5, 17'h555, 8'h10, "R4");
        check(nr == 1, "R6", "chip erase poll count", nr, 1);
        check(e == 1'b0, "R4", "chip erase err", e, 0);
    endtask

    task automatic t_timeout_then_clear();
        logic e;
        model_setup(17'h04000, 1000, 8'h00, 8'hFF);
        send(2'b01, 17'h04000, 8'h00);
        wait_done(e);
        check(e == 1'b1, "R7", "timeout err", e, 1);
        check(nr == PMAX, "R7", "reads at timeout", nr, PMAX);
        repeat (20) tick();
        check(nr == PMAX, "R7", "reads after timeout", nr, PMAX);
        check(err == 1'b1, "R9", "err held while idle", err, 1);
        model_setup(17'h00100, 0, 8'h00, 8'h3C);
        send(2'b00, 17'h00100, 8'h3C);
        check(err == 1'b0, "R8", "err cleared on take", err, 1'b0);
        wait_done(e);
        check(e == 1'b0, "R5", "program after timeout err", e, 0);
    endtask

    task automatic t_abort();
        logic e;
        model_setup(17'h08000, 0, 8'h00, 8'hFF);
        send(2'b01, 17'h08000, 8'h00);
        while (nw < 2) tick();
        req_abort = 1'b1;
        tick();
        req_abort = 1'b0;
        wait_done(e);
        check(e == 1'b1, "R12", "abort err", e, 1);
        check(nw == 2, "R12", "writes before abort", nw, 2);
        check(nr == 0, "R12", "reads after abort", nr, 0);
        // abort while idle has no effect
        req_abort = 1'b1;
        tick();
        req_abort = 1'b0;
        model_setup(17'h00042, 1, 8'h00, 8'hC3);
        send(2'b00, 17'h00042, 8'hC3);
        wait_done(e);
        check(nw == 4, "R12", "restarted write count", nw, 4);
        check_write(0, 17'h555, 8'hAA, "R12");
        check_write(3, 17'h00042, 8'hC3, "R12");
        check(e == 1'b0, "R12", "err after idle abort", e, 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    initial begin
        #50000000;
        nchk++;
        nbad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_program();
        t_sector_busy_req();
        t_chip();
        t_timeout_then_clear();
        t_abort();
        repeat (5) tick();
        finish_run();
    end
endmodule